// File: doc/BRIEF.md
# Recovered-Data Output Formatter

This block sits after the clock-recovery stage of a receiver. It takes the retimed bit stream, one bit per pulse of a bit-valid enable, and presents it in one of two formats. In parallel mode, groups of consecutive bits are packed into a nibble. In serial mode, each bit is presented on its own. Either format comes with an output clock that runs at full or half rate. At full rate the clock gives one rising edge per data unit. At half rate it gives one transition per unit, so both edges carry data for DDR capture.

Control inputs set four things:
- the format,
- which end of the nibble carries the earliest bit,
- the clock rate for each format,
- independent shut-offs for the data and clock outputs.

A disabled output is driven low, not released. The output clock is a registered level. It changes one system-clock cycle after the data it qualifies, so the data is stable for one cycle before each clock transition. Bits may arrive no faster than every other system-clock cycle.

Top module: `rx_out_formatter`

## Requirements
- R1: Under reset, and before any bit has been accepted, `dout` is all zeros and `oclk` is 0.
- R2: In parallel mode (`cfg_ser_mode`=0) with `cfg_swap`=0, the cycle after the fourth bit of a group is accepted, `dout` holds that group with the earliest bit on `dout[3]` and the latest bit on `dout[0]`.
- R3: In parallel mode with `cfg_swap`=1, the group is presented reversed: the earliest bit is on `dout[0]` and the latest is on `dout[3]`.
- R4: In parallel mode, a presented nibble stays unchanged until the last bit of the next group is accepted.
- R5: In serial mode (`cfg_ser_mode`=1), the cycle after a bit is accepted, `dout[0]` carries that bit and `dout[3:1]` are 0.
- R6: At full rate, `oclk` is high for exactly one cycle, starting one cycle after each data update. Full rate is selected in parallel mode by `cfg_par_half`=0, and in serial mode by `cfg_ser_full`=1.
- R7: At half rate, `oclk` changes level one cycle after each data update. Half rate is selected in parallel mode by `cfg_par_half`=1, and in serial mode by `cfg_ser_full`=0.
- R8: With `cfg_dat_off`=1, `dout` is all zeros.
- R9: With `cfg_clk_off`=1, `oclk` is 0.
- R10: A bit is accepted only in a cycle with `bit_vld`=1, and `bit_in` is ignored otherwise. Two `bit_vld` pulses are always separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Bit-valid enable, one pulse per received bit |
| bit_in | input | 1 | Retimed received bit |
| cfg_ser_mode | input | 1 | 0 = parallel nibble output, 1 = serial output |
| cfg_swap | input | 1 | 0 = earliest bit on MSB, 1 = earliest bit on LSB |
| cfg_par_half | input | 1 | Parallel clock: 0 = full rate, 1 = half rate |
| cfg_ser_full | input | 1 | Serial clock: 0 = half rate, 1 = full rate |
| cfg_dat_off | input | 1 | 1 forces the data output low |
| cfg_clk_off | input | 1 | 1 forces the output clock low |
| dout | output | NIB_W (4) | Nibble, or serial bit on bit 0 |
| oclk | output | 1 | Output clock level |

## Verification
Asymmetric patterns such as 1011 and 1000 are sent in both bit orders. Each of these patterns differs from its own reverse, so a wrong or missing swap shows up. Serial groups are chosen so that the last bit differs from the first, which shows whether the latest bit or a stale one is presented. Half-rate groups are sent an odd number of times, so the expected clock level flips and a stuck or full-rate clock is exposed. Idle cycles with a toggling `bit_in`, and half-finished groups, show that data moves only on accepted bits and only on complete groups.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   typedef struct packed {
      logic ser_mode;
      logic swap;
      logic par_half;
      logic ser_full;
      logic dat_off;
      logic clk_off;
   } fmt_cfg_t;

   function automatic logic half_rate_sel(fmt_cfg_t c);
      return c.ser_mode ? ~c.ser_full : c.par_half;
   endfunction
endpackage

// File: rtl/fmt_nib_asm.sv
module fmt_nib_asm #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             swap,
   output logic [NIB_W-1:0] nib_q,
   output logic             grp_done
);
   localparam int CW = (NIB_W > 2) ? $clog2(NIB_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(NIB_W - 1);

   logic [CW-1:0]    cnt;
   logic [NIB_W-2:0] sh;
   logic [NIB_W-1:0] full_w;
   logic [NIB_W-1:0] rev_w;

   assign full_w   = {sh, bit_in};
   assign grp_done = bit_vld && (cnt == LAST);

   for (genvar i = 0; i < NIB_W; i++) begin : g_rev
      assign rev_w[i] = full_w[NIB_W-1-i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         sh    <= '0;
         nib_q <= '0;
      end else if (bit_vld) begin
         sh  <= full_w[NIB_W-2:0];
         cnt <= grp_done ? '0 : cnt + 1'b1;
         if (grp_done) nib_q <= swap ? rev_w : full_w;
      end
   end
endmodule

// File: rtl/fmt_clkgen.sv
module fmt_clkgen #(
   parameter bit LAG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic half_sel,
   output logic clk_out
);
   logic ev_d;
   logic pulse_q;
   logic tog_q;

   if (LAG) begin : g_lag
      logic ev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ev_q <= 1'b0;
         else        ev_q <= ev;
      end
      assign ev_d = ev_q;
   end else begin : g_nolag
      assign ev_d = ev;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         tog_q   <= 1'b0;
      end else begin
         pulse_q <= ev_d;
         tog_q   <= tog_q ^ ev_d;
      end
   end

   assign clk_out = half_sel ? tog_q : pulse_q;
endmodule

// File: rtl/fmt_dsel.sv
module fmt_dsel #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             ser_mode,
   input  logic             dat_off,
   input  logic [NIB_W-1:0] nib,
   output logic [NIB_W-1:0] dout
);
   logic ser_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ser_q <= 1'b0;
      else if (bit_vld) ser_q <= bit_in;
   end

   always_comb begin
      if (dat_off)       dout = '0;
      else if (ser_mode) dout = {{(NIB_W-1){1'b0}}, ser_q};
      else               dout = nib;
   end
endmodule

// File: rtl/rx_out_formatter.sv
module rx_out_formatter
   import fmt_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             cfg_ser_mode,
   input  logic             cfg_swap,
   input  logic             cfg_par_half,
   input  logic             cfg_ser_full,
   input  logic             cfg_dat_off,
   input  logic             cfg_clk_off,
   output logic [NIB_W-1:0] dout,
   output logic             oclk
);
   if (NIB_W < 2) begin : g_bad_width
      $error("rx_out_formatter: NIB_W must be at least 2");
   end

   fmt_cfg_t         cfg;
   logic [NIB_W-1:0] nib;
   logic             grp_done;
   logic             ev;
   logic             clk_raw;

   assign cfg = '{ser_mode: cfg_ser_mode, swap: cfg_swap, par_half: cfg_par_half,
                  ser_full: cfg_ser_full, dat_off: cfg_dat_off, clk_off: cfg_clk_off};

   fmt_nib_asm #(.NIB_W(NIB_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .swap(cfg.swap), .nib_q(nib), .grp_done(grp_done)
   );

   assign ev = cfg.ser_mode ? bit_vld : grp_done;

   fmt_clkgen #(.LAG(1'b1)) u_clk (
      .clk(clk), .rst_n(rst_n), .ev(ev),
      .half_sel(half_rate_sel(cfg)), .clk_out(clk_raw)
   );

   fmt_dsel #(.NIB_W(NIB_W)) u_dsel (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .ser_mode(cfg.ser_mode), .dat_off(cfg.dat_off), .nib(nib), .dout(dout)
   );

   assign oclk = clk_raw & ~cfg.clk_off;
endmodule

// File: rtl/rx_out_formatter_chk.sv
module rx_out_formatter_chk #(
   parameter int NIB_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_vld,
   input logic             bit_in,
   input logic             cfg_ser_mode,
   input logic             cfg_swap,
   input logic             cfg_par_half,
   input logic             cfg_ser_full,
   input logic             cfg_dat_off,
   input logic             cfg_clk_off,
   input logic [NIB_W-1:0] dout,
   input logic             oclk
);
   logic full_sel;
   assign full_sel = cfg_ser_mode ? cfg_ser_full : ~cfg_par_half;

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ser_mode && !$past(cfg_ser_mode) && !cfg_dat_off && !$past(cfg_dat_off)
       && !$past(bit_vld)) |-> $stable(dout));

   p_serial_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ser_mode && $past(cfg_ser_mode) && !cfg_dat_off && $past(bit_vld))
      |-> (dout == {{(NIB_W-1){1'b0}}, $past(bit_in)}));

   p_full_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oclk && full_sel) |=> (!oclk || !$stable(full_sel) || !$stable(cfg_ser_mode)));

   p_data_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dat_off |-> (dout == '0));

   p_clk_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk_off |-> !oclk);

   p_vld_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |=> !bit_vld);
endmodule

bind rx_out_formatter rx_out_formatter_chk #(.NIB_W(NIB_W)) u_chk (.*);

// File: tb/rx_out_formatter_tb.sv
module rx_out_formatter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       ser_mode = 1'b0, swap = 1'b0, par_half = 1'b0, ser_full = 1'b0;
   logic       dat_off = 1'b0, clk_off = 1'b0;
   logic [3:0] dout;
   logic       oclk;
   int         checks = 0;
   int         errors = 0;
   logic       tog = 1'b0;

   always #2 clk = ~clk;

   rx_out_formatter #(.NIB_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .cfg_ser_mode(ser_mode), .cfg_swap(swap), .cfg_par_half(par_half),
      .cfg_ser_full(ser_full), .cfg_dat_off(dat_off), .cfg_clk_off(clk_off),
      .dout(dout), .oclk(oclk)
   );

   // [15]ser [14]swap [13]par_half [12]ser_full [11]dat_off [10]clk_off [9:6]bits, first at [9] [5:2]expected dout
   localparam logic [15:0] VEC [8] = '{
      16'b0_0_0_0_0_0_1011_1011_00,   // R2
      16'b0_1_0_0_0_0_1011_1101_00,   // R3
      16'b0_0_1_0_0_0_0110_0110_00,   // R2 R7
      16'b0_1_1_0_0_0_1000_0001_00,   // R3 R7
      16'b1_0_0_1_0_0_0101_0001_00,   // R5 R6
      16'b1_0_0_0_0_0_1110_0000_00,   // R5 R7
      16'b0_0_0_0_1_0_1111_0000_00,   // R8
      16'b0_0_0_0_0_1_0011_0011_00    // R9
   };

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one bit plus an idle cycle; returns at the negedge two edges after acceptance
   task automatic send_bit(logic b);
      bit_vld = 1'b1;
      bit_in  = b;
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = ~b;
      @(negedge clk);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 dout in reset", dout, 4'h0);
      check("R1 oclk in reset", {3'b0, oclk}, 4'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 dout after reset", dout, 4'h0);
      check("R1 oclk after reset", {3'b0, oclk}, 4'h0);

      for (int i = 0; i < 8; i++) begin
         logic [15:0] v;
         logic        half;
         logic        exp_clk;
         v = VEC[i];
         {ser_mode, swap, par_half, ser_full, dat_off, clk_off} = v[15:10];
         for (int k = 3; k >= 0; k--) send_bit(v[6+k]);
         tog  = ser_mode ? tog : ~tog;
         half = ser_mode ? ~ser_full : par_half;
         exp_clk = clk_off ? 1'b0 : (half ? tog : 1'b1);
         check($sformatf("R2 R3 R5 R8 vector %0d dout", i), dout, v[5:2]);
         check($sformatf("R6 R7 R9 vector %0d oclk", i), {3'b0, oclk}, {3'b0, exp_clk});
      end

      // R6: full-rate pulse lasts one cycle
      {ser_mode, swap, par_half, ser_full, dat_off, clk_off} = 6'b0;
      @(negedge clk);
      check("R6 full-rate pulse ends", {3'b0, oclk}, 4'h0);

      // R4: nibble held while the next group is half assembled
      send_bit(1'b0);
      send_bit(1'b1);
      check("R4 nibble held mid-group", dout, 4'b0011);

      // R10: idle cycles with a toggling bit_in take no bits
      repeat (6) begin
         bit_in = ~bit_in;
         @(negedge clk);
      end
      check("R10 idle bits ignored mid-group", dout, 4'b0011);
      send_bit(1'b1);
      send_bit(1'b0);
      check("R10 R2 group from accepted bits only", dout, 4'b0110);

      // R9: the half-rate level is still tracked while the clock is forced low
      par_half = 1'b1;
      tog = ~tog;                          // parity after the last complete group
      clk_off = 1'b1;
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
      tog = ~tog;
      check("R9 clock forced low", {3'b0, oclk}, 4'h0);
      clk_off = 1'b0;
      #0;
      check("R7 half-rate level restored", {3'b0, oclk}, {3'b0, tog});
      check("R2 nibble under clock off", dout, 4'b1100);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule